// File: doc/BRIEF.md
# Extended Golay (24,12,8) Hard-Decision Decoder

This block takes one received 24-bit word per cycle from the extended binary Golay code, a self-dual code with length 24, dimension 12 and minimum distance 8. It returns the 12 information bits with every error pattern of weight three or less removed. The block works from two 12-bit syndromes: the first comes from the received word, and the second is the first one multiplied by the code matrix. It tests the Hamming weights of these syndromes, and of each syndrome XORed with each matrix row, to locate the errors. No lookup table of syndromes is used.

Words enter with a valid strobe and leave a fixed number of cycles later with a matching valid strobe. There is no back-pressure. When no pattern of weight three or less explains the syndrome, the block sets an uncorrectable flag and returns the received information bits unchanged. A parameter chooses whether a register sits between the syndrome stage and the weight/decision stage.

Top module: `golay24_decoder`

## Requirements
- R1: A word is laid out with the information bits in [23:12] and the check bits in [11:0]. Check bit j is the XOR over k of info[k]·M[k][j]. Row 0 of M has column 0 clear and columns 1..11 set. A row k ≥ 1 has column 0 set, and its column c (1..11) equals character (c+k−2) mod 11 of the string 11011100010, where character 0 is the leftmost. An error-free word returns its information bits, with the uncorrectable flag low.
- R2: Any pattern of one to three errors that falls only in bits [11:0] is corrected.
- R3: Exactly one error in bits [23:12], together with zero to two errors in bits [11:0], is corrected.
- R4: Two or three errors that fall only in bits [23:12] are corrected.
- R5: Two errors in bits [23:12] together with one error in bits [11:0] are corrected.
- R6: Any error pattern of weight exactly four sets the uncorrectable flag, and the output data then equals received bits [23:12].
- R7: With the default configuration, out_valid is high exactly two clock cycles after each cycle in which in_valid is high, and at no other time.
- R8: While rst_n is low, out_valid, out_data and out_uncorr are all zero.
- R9: The uncorrectable flag stays low for every error pattern of weight three or less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | in_word holds a word to decode this cycle |
| in_word | input | 24 | Received word: information bits [23:12], check bits [11:0] |
| out_valid | output | 1 | out_data and out_uncorr belong to a decoded word |
| out_data | output | 12 | Corrected information bits |
| out_uncorr | output | 1 | No pattern of weight three or less matches the syndrome |

## Verification
Each accepted word appears at the outputs on the second rising edge after the edge that sampled it. The bench drives each word on a falling edge and stamps it with the number of rising edges seen so far. On every falling edge it compares the outputs against the oldest stamped word whose stamp is exactly two edges old. The outputs are then stable, so the data, the flag and the presence or absence of out_valid are all read in the cycle they are due. A valid strobe that appears with no word due counts as a latency failure.

// File: rtl/golay24_pkg.sv
package golay24_pkg;
   localparam int unsigned HALF = 12;
   localparam int unsigned FULL = 2 * HALF;
   localparam int unsigned WTW  = $clog2(HALF + 1);
   localparam logic [10:0] CYC_SEED = 11'b01000111011;
   localparam logic [WTW-1:0] LIM_ROW = WTW'(2);
   localparam logic [WTW-1:0] LIM_SYN = WTW'(3);

   typedef logic [HALF-1:0] half_t;

   // row k of the 12x12 code matrix, bit c = column c
   function automatic half_t a_row(input int unsigned k);
      half_t r;
      if (k == 0) begin
         r = {{(HALF-1){1'b1}}, 1'b0};
      end else begin
         r[0] = 1'b1;
         for (int unsigned c = 1; c < HALF; c++)
            r[c] = CYC_SEED[(c + k - 2) % (HALF - 1)];
      end
      return r;
   endfunction

   function automatic logic [WTW-1:0] weight(input half_t v);
      logic [WTW-1:0] n;
      n = '0;
      for (int unsigned i = 0; i < HALF; i++)
         n = n + {{(WTW-1){1'b0}}, v[i]};
      return n;
   endfunction

   // row vector times matrix
   function automatic half_t mul_a(input half_t v);
      half_t acc;
      acc = '0;
      for (int unsigned k = 0; k < HALF; k++)
         if (v[k]) acc = acc ^ a_row(k);
      return acc;
   endfunction
endpackage

// File: rtl/golay24_syn.sv
module golay24_syn
   import golay24_pkg::*;
(
   input  half_t msg,
   input  half_t chk,
   output half_t syn_a,
   output half_t syn_b
);
   always_comb begin
      syn_a = chk ^ mul_a(msg);
      syn_b = mul_a(syn_a);
   end
endmodule

// File: rtl/golay24_loc.sv
module golay24_loc
   import golay24_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  en,
   input  half_t syn_a,
   input  half_t syn_b,
   output half_t fix,
   output logic  bad
);
   half_t hit_s;
   half_t hit_q;
   half_t alt [HALF];
   half_t alt_or;
   logic  fit_s;
   logic  fit_q;

   assign fit_s = (weight(syn_a) <= LIM_SYN);
   assign fit_q = (weight(syn_b) <= LIM_SYN);

   for (genvar i = 0; i < HALF; i++) begin : g_row
      localparam half_t ROW = a_row(i);
      assign hit_s[i] = (weight(syn_a ^ ROW) <= LIM_ROW);
      assign hit_q[i] = (weight(syn_b ^ ROW) <= LIM_ROW);
      assign alt[i]   = hit_q[i] ? (syn_b ^ ROW) : '0;
   end

   always_comb begin
      alt_or = '0;
      for (int unsigned i = 0; i < HALF; i++)
         alt_or = alt_or | alt[i];
   end

   always_comb begin
      fix = '0;
      bad = 1'b0;
      if (fit_s)       fix = '0;
      else if (|hit_s) fix = hit_s;
      else if (fit_q)  fix = syn_b;
      else if (|hit_q) fix = alt_or;
      else             bad = 1'b1;
   end

   // R3
   s_row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> $onehot0(hit_s));

   // R5
   q_row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> $onehot0(hit_q));

   // R9
   fix_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !bad) |-> ($countones(fix) <= 3));
endmodule

// File: rtl/golay24_decoder.sv
module golay24_decoder
   import golay24_pkg::*;
#(
   parameter int unsigned MID_REG = 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [FULL-1:0]  in_word,
   output logic             out_valid,
   output logic [HALF-1:0]  out_data,
   output logic             out_uncorr
);
   localparam int unsigned LAT = MID_REG + 1;

   if (MID_REG > 1) begin : g_bad_cfg
      $error("golay24_decoder: MID_REG must be 0 or 1");
   end

   half_t in_msg, in_chk, sa, sb;
   half_t st_msg, st_sa, st_sb;
   logic  st_v;
   half_t fix;
   logic  bad;

   assign in_msg = in_word[FULL-1:HALF];
   assign in_chk = in_word[HALF-1:0];

   golay24_syn u_syn (
      .msg   (in_msg),
      .chk   (in_chk),
      .syn_a (sa),
      .syn_b (sb)
   );

   if (MID_REG == 1) begin : g_mid
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_v   <= 1'b0;
            st_msg <= '0;
            st_sa  <= '0;
            st_sb  <= '0;
         end else begin
            st_v <= in_valid;
            if (in_valid) begin
               st_msg <= in_msg;
               st_sa  <= sa;
               st_sb  <= sb;
            end
         end
      end
   end else begin : g_flow
      assign st_v   = in_valid;
      assign st_msg = in_msg;
      assign st_sa  = sa;
      assign st_sb  = sb;
   end

   golay24_loc u_loc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (st_v),
      .syn_a (st_sa),
      .syn_b (st_sb),
      .fix   (fix),
      .bad   (bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_data   <= '0;
         out_uncorr <= 1'b0;
      end else begin
         out_valid <= st_v;
         if (st_v) begin
            out_data   <= st_msg ^ fix;
            out_uncorr <= bad;
         end
      end
   end

   // R7
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, LAT));

   // R8
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_state_chk: assert (!out_valid && !out_uncorr && (out_data == '0));
      end
   end
endmodule

// File: tb/golay24_decoder_tb.sv
`timescale 1ns/1ps
module golay24_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [23:0] in_word = '0;
   logic        out_valid;
   logic [11:0] out_data;
   logic        out_uncorr;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int n_sent = 0;

   int          qt[$];
   logic [11:0] qd[$];
   bit          qf[$];
   string       qr[$];

   golay24_decoder u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_word    (in_word),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .out_uncorr (out_uncorr)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [11:0] tb_row(input int k);
      string pat;
      logic [11:0] r;
      pat = "11011100010";
      r = '0;
      if (k == 0) r = 12'hFFE;
      else begin
         r[0] = 1'b1;
         for (int c = 1; c < 12; c++)
            r[c] = (pat[(c + k - 2) % 11] == "1");
      end
      return r;
   endfunction

   function automatic logic [11:0] tb_parity(input logic [11:0] d);
      logic [11:0] p;
      p = '0;
      for (int k = 0; k < 12; k++)
         if (d[k]) p = p ^ tb_row(k);
      return p;
   endfunction

   function automatic string tb_tag(input logic [23:0] e);
      int nd, np;
      nd = $countones(e[23:12]);
      np = $countones(e[11:0]);
      if (nd + np == 0) return "R1";
      if (nd + np >= 4) return "R6";
      if (nd == 0)      return "R2";
      if (nd == 1)      return "R3";
      if (np == 0)      return "R4";
      return "R5";
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [23:0] got, input logic [23:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic send(input logic [11:0] d, input logic [23:0] e);
      logic [23:0] w;
      bit f;
      @(negedge clk);
      w = {d, tb_parity(d)} ^ e;
      f = ($countones(e) >= 4);
      in_valid = 1'b1;
      in_word  = w;
      qt.push_back(cyc);
      qd.push_back(f ? w[23:12] : d);
      qf.push_back(f);
      qr.push_back(tb_tag(e));
      n_sent++;
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
      in_word  = 24'($urandom);
   endtask

   task automatic send_r(input logic [23:0] e);
      send(12'($urandom), e);
      if (n_sent % 97 == 0) idle();
   endtask

   // output monitor: every word is due two rising edges after it was driven
   always @(negedge clk) begin
      bit due;
      if (rst_n) begin
         due = (qt.size() > 0) && (qt[0] == cyc - 2);
         if (due) begin
            check(out_valid == 1'b1, "R7", "out_valid when due", 24'(out_valid), 24'd1);
            if (out_valid) begin
               check(out_data == qd[0], qr[0], "data", 24'(out_data), 24'(qd[0]));
               check(out_uncorr == qf[0], qf[0] ? "R6" : "R9", "flag",
                     24'(out_uncorr), 24'(qf[0]));
            end
            void'(qt.pop_front());
            void'(qd.pop_front());
            void'(qf.pop_front());
            void'(qr.pop_front());
         end else if (out_valid) begin
            check(1'b0, "R7", "unexpected out_valid", 24'd1, 24'd0);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [23:0] e;
      void'($urandom(32'd24812));
      // R8: reset state
      repeat (3) begin
         @(negedge clk);
         check(out_valid == 1'b0, "R8", "out_valid in reset", 24'(out_valid), 24'd0);
         check(out_data == '0, "R8", "out_data in reset", 24'(out_data), 24'd0);
         check(out_uncorr == 1'b0, "R8", "out_uncorr in reset", 24'(out_uncorr), 24'd0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      idle();

      // R1: clean words, directed then random
      send(12'h000, '0);
      send(12'hFFF, '0);
      send(12'h5A3, '0);
      idle();
      for (int i = 0; i < 20; i++) send_r('0);

      // single errors (R2, R3)
      for (int p = 0; p < 24; p++) send_r(24'd1 << p);
      // double errors (R2, R3, R4)
      for (int p = 0; p < 24; p++)
         for (int q = p + 1; q < 24; q++)
            send_r((24'd1 << p) | (24'd1 << q));
      // triple errors (R2..R5)
      for (int p = 0; p < 24; p++)
         for (int q = p + 1; q < 24; q++)
            for (int r = q + 1; r < 24; r++)
               send_r((24'd1 << p) | (24'd1 << q) | (24'd1 << r));

      // R6: weight-four patterns, directed then random
      send(12'h000, 24'h00000F);
      send(12'hABC, 24'hF00000);
      send(12'h3C7, 24'h003003);
      for (int n = 0; n < 400; n++) begin
         e = '0;
         while ($countones(e) < 4) e = e | (24'd1 << ($urandom % 24));
         send_r(e);
      end

      repeat (4) idle();
      // R7: every word came out
      check(qt.size() == 0, "R7", "words left undelivered", 24'(qt.size()), 24'd0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule